// File: doc/BRIEF.md
# Power-Management I/O Decode and SCI Steering

This block holds two configuration registers of a legacy I/O bridge function. The first is an 8-bit power-management control register at configuration byte offset 44h, which lives in byte lane 0 of dword 11h. The second is a 32-bit GPIO window base register at offsets 48h to 4Bh, which fills dword 12h. Both are reached through a dword-addressed configuration port that has byte enables. A write takes effect on the clock edge that samples it. Read data is combinational from the addressed dword.

From these registers and the inputs, the block produces three I/O-range hit signals for a 16-bit I/O address:
- a 128-byte ACPI window, compared against an externally held base and gated by an enable bit;
- the two fixed APM ports B2h and B3h, which are always decoded;
- a 64-byte GPIO window.

The block also steers one SCI event onto one of seven interrupt lines. Three of them (IRQ9 to IRQ11) are active-high. Four of them (IRQ20 to IRQ23) are active-low and may be used only while the interrupt controller's extended mode input is high.

Top module: `pm_decode_router`

## Requirements
- R1: After reset, dword 11h reads 00000000h and dword 12h reads 00000001h.
- R2: A write to dword 11h with byte enable bit 0 set stores data bit 7 as the decode enable and bits 2:0 as the SCI route code. Bits 6:3 and 31:8 read 0. The new value is readable in the cycle after the write. A write with byte enable bit 0 clear changes nothing.
- R3: `acpiHit` is high exactly when the enable bit (bit 7 of dword 11h) is 1 and `ioAddr[15:7]` equals `acpiBase`.
- R4: `apmHit` is high exactly when `ioAddr` is 00B2h or 00B3h, whatever the enable bit holds.
- R5: In dword 12h, bits 7:6 are written through byte lane 0 and bits 15:8 through byte lane 1. Bit 0 always reads 1. Bits 31:16 and 5:1 always read 0, whatever is written.
- R6: `gpioHit` is high exactly when `ioAddr[15:6]` equals bits 15:6 of dword 12h.
- R7: Route codes 000, 001 and 010 drive `sciEvent` active-high onto `irqLow[0]` (IRQ9), `irqLow[1]` (IRQ10) and `irqLow[2]` (IRQ11) respectively.
- R8: Route codes 100 to 111, while `apicEn` is 1, drive `sciEvent` active-low onto `irqHighN[0]` to `irqHighN[3]` (IRQ20 to IRQ23) in order.
- R9: Route code 011, and codes 100 to 111 while `apicEn` is 0, deliver the SCI to no line.
- R10: Every line not carrying an asserted SCI rests inactive: `irqLow` bits low and `irqHighN` bits high. At most one line is active at any time.
- R11: Dwords other than 11h and 12h read 0, and writes to them leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSel | input | 1 | Configuration access valid |
| cfgWrite | input | 1 | Access is a write when high |
| cfgDwAddr | input | 6 | Configuration dword address (byte offset / 4) |
| cfgByteEn | input | 4 | Write byte enables |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data of the addressed dword, combinational |
| ioAddr | input | 16 | I/O address under decode |
| acpiBase | input | 9 | Upper bits 15:7 of the ACPI window base |
| acpiHit | output | 1 | Address falls in the enabled ACPI window |
| apmHit | output | 1 | Address is an APM port |
| gpioHit | output | 1 | Address falls in the GPIO window |
| apicEn | input | 1 | Extended interrupt targets permitted |
| sciEvent | input | 1 | SCI request, active-high |
| irqLow | output | 3 | IRQ9 to IRQ11, active-high |
| irqHighN | output | 4 | IRQ20 to IRQ23, active-low |

## Verification
The hit signals, the interrupt lines and the read data have no register on their path, so they are due in the same cycle as the I/O address, the SCI, the extended-mode input or the read address that produces them. A register write is due one edge later. The bench drives every input at the falling edge and compares all six outputs against its model one nanosecond later. It updates the model's registers only at the rising edge that samples the write. A read or decode in the cycle after a write therefore checks the new value, and a check in the write cycle itself checks the old one.

// File: rtl/pm_route_pkg.sv
package pm_route_pkg;
  localparam int unsigned CFG_DW_AW  = 6;
  localparam int unsigned CFG_DATA_W = 32;
  localparam int unsigned CFG_LANES  = CFG_DATA_W / 8;

  localparam logic [CFG_DW_AW-1:0] ACPI_CTL_DW = 6'h11;
  localparam logic [CFG_DW_AW-1:0] GPIO_BAR_DW = 6'h12;

  // strobes from the access decoder to the register datapath
  typedef struct packed {
    logic                 acpiWr;
    logic [CFG_LANES-1:0] gpioLaneWr;
    logic                 rdAcpi;
    logic                 rdGpio;
  } cfgStrobe_t;
endpackage

// File: rtl/pm_cfg_ctrl.sv
module pm_cfg_ctrl
  import pm_route_pkg::*;
(
  input  logic                 cfgSel,
  input  logic                 cfgWrite,
  input  logic [CFG_DW_AW-1:0] cfgDwAddr,
  input  logic [CFG_LANES-1:0] cfgByteEn,
  output cfgStrobe_t           strobe
);
  logic wrAccess;
  logic hitAcpi;
  logic hitGpio;

  always_comb begin
    wrAccess = cfgSel && cfgWrite;
    hitAcpi  = (cfgDwAddr == ACPI_CTL_DW);
    hitGpio  = (cfgDwAddr == GPIO_BAR_DW);

    strobe.acpiWr     = wrAccess && hitAcpi && cfgByteEn[0];
    strobe.gpioLaneWr = (wrAccess && hitGpio) ? cfgByteEn : '0;
    strobe.rdAcpi     = hitAcpi;
    strobe.rdGpio     = hitGpio;
  end
endmodule

// File: rtl/pm_cfg_datapath.sv
module pm_cfg_datapath
  import pm_route_pkg::*;
#(
  parameter int unsigned IO_AW         = 16,
  parameter int unsigned ACPI_WIN_LOG2 = 7,
  parameter int unsigned GPIO_WIN_LOG2 = 6,
  parameter int unsigned SEL_W         = 3,
  parameter int unsigned NUM_LOW       = 3,
  parameter int unsigned NUM_HIGH      = 4,
  parameter int unsigned HIGH_BASE     = 4,
  parameter int unsigned ACPI_EN_BIT   = 7,
  parameter logic [15:0] APM_PORT      = 16'h00B2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cfgStrobe_t                     strobe,
  input  logic [CFG_DATA_W-1:0]          cfgWrData,
  output logic [CFG_DATA_W-1:0]          cfgRdData,
  input  logic [IO_AW-1:0]               ioAddr,
  input  logic [IO_AW-ACPI_WIN_LOG2-1:0] acpiBase,
  output logic                           acpiHit,
  output logic                           apmHit,
  output logic                           gpioHit,
  input  logic                           apicEn,
  input  logic                           sciEvent,
  output logic [NUM_LOW-1:0]             irqLow,
  output logic [NUM_HIGH-1:0]            irqHighN
);
  localparam int unsigned GPIO_BW = IO_AW - GPIO_WIN_LOG2;

  logic               acpiEnQ;
  logic [SEL_W-1:0]   sciSelQ;
  logic [GPIO_BW-1:0] gpioBaseQ;
  logic               unusedWrBits;

  assign unusedWrBits = ^{cfgWrData, strobe.gpioLaneWr};

  // power-management control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acpiEnQ <= 1'b0;
      sciSelQ <= '0;
    end else if (strobe.acpiWr) begin
      acpiEnQ <= cfgWrData[ACPI_EN_BIT];
      sciSelQ <= cfgWrData[SEL_W-1:0];
    end
  end

  // GPIO base: each writable bit follows its own byte lane
  for (genvar b = 0; b < GPIO_BW; b++) begin : g_gpioBit
    localparam int unsigned POS = b + GPIO_WIN_LOG2;
    always_ff @(posedge clk) begin
      if (!rstN)
        gpioBaseQ[b] <= 1'b0;
      else if (strobe.gpioLaneWr[POS/8])
        gpioBaseQ[b] <= cfgWrData[POS];
    end
  end

  // read mux
  always_comb begin
    cfgRdData = '0;
    if (strobe.rdAcpi) begin
      cfgRdData[SEL_W-1:0]  = sciSelQ;
      cfgRdData[ACPI_EN_BIT] = acpiEnQ;
    end else if (strobe.rdGpio) begin
      cfgRdData[IO_AW-1:GPIO_WIN_LOG2] = gpioBaseQ;
      cfgRdData[0]                     = 1'b1;
    end
  end

  // I/O range decode
  always_comb begin
    acpiHit = acpiEnQ && (ioAddr[IO_AW-1:ACPI_WIN_LOG2] == acpiBase);
    apmHit  = (ioAddr == IO_AW'(APM_PORT)) || (ioAddr == IO_AW'(APM_PORT + 16'd1));
    gpioHit = (ioAddr[IO_AW-1:GPIO_WIN_LOG2] == gpioBaseQ);
  end

  // SCI steering
  for (genvar j = 0; j < NUM_LOW; j++) begin : g_lowIrq
    assign irqLow[j] = sciEvent && (sciSelQ == SEL_W'(j));
  end
  for (genvar k = 0; k < NUM_HIGH; k++) begin : g_highIrq
    assign irqHighN[k] = !(sciEvent && apicEn && (sciSelQ == SEL_W'(HIGH_BASE + k)));
  end
endmodule

// File: rtl/pm_decode_router.sv
module pm_decode_router
  import pm_route_pkg::*;
#(
  parameter int unsigned IO_AW         = 16,
  parameter int unsigned ACPI_WIN_LOG2 = 7,
  parameter int unsigned GPIO_WIN_LOG2 = 6,
  parameter int unsigned NUM_LOW       = 3,
  parameter int unsigned NUM_HIGH      = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgSel,
  input  logic                           cfgWrite,
  input  logic [CFG_DW_AW-1:0]           cfgDwAddr,
  input  logic [CFG_LANES-1:0]           cfgByteEn,
  input  logic [CFG_DATA_W-1:0]          cfgWrData,
  output logic [CFG_DATA_W-1:0]          cfgRdData,
  input  logic [IO_AW-1:0]               ioAddr,
  input  logic [IO_AW-ACPI_WIN_LOG2-1:0] acpiBase,
  output logic                           acpiHit,
  output logic                           apmHit,
  output logic                           gpioHit,
  input  logic                           apicEn,
  input  logic                           sciEvent,
  output logic [NUM_LOW-1:0]             irqLow,
  output logic [NUM_HIGH-1:0]            irqHighN
);
  cfgStrobe_t strobe;

  pm_cfg_ctrl ctrl_i (
    .cfgSel    (cfgSel),
    .cfgWrite  (cfgWrite),
    .cfgDwAddr (cfgDwAddr),
    .cfgByteEn (cfgByteEn),
    .strobe    (strobe)
  );

  pm_cfg_datapath #(
    .IO_AW         (IO_AW),
    .ACPI_WIN_LOG2 (ACPI_WIN_LOG2),
    .GPIO_WIN_LOG2 (GPIO_WIN_LOG2),
    .NUM_LOW       (NUM_LOW),
    .NUM_HIGH      (NUM_HIGH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .ioAddr    (ioAddr),
    .acpiBase  (acpiBase),
    .acpiHit   (acpiHit),
    .apmHit    (apmHit),
    .gpioHit   (gpioHit),
    .apicEn    (apicEn),
    .sciEvent  (sciEvent),
    .irqLow    (irqLow),
    .irqHighN  (irqHighN)
  );
endmodule

// File: rtl/pm_decode_router_chk.sv
module pm_decode_router_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgSel,
  input logic        cfgWrite,
  input logic [5:0]  cfgDwAddr,
  input logic [31:0] cfgRdData,
  input logic [15:0] ioAddr,
  input logic        apmHit,
  input logic        sciEvent,
  input logic [2:0]  irqLow,
  input logic [3:0]  irqHighN
);
  // R4: the fixed APM ports always hit
  p_apm_always_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr == 16'h00B2 || ioAddr == 16'h00B3) |-> apmHit);

  // R5: fixed bits of the GPIO base dword
  p_gpio_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDwAddr == 6'h12) |-> (cfgRdData[0] && cfgRdData[31:16] == 16'h0 && cfgRdData[5:1] == 5'h0));

  // R2: reserved bits of the control dword
  p_acpi_reserved_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDwAddr == 6'h11) |-> (cfgRdData[6:3] == 4'h0 && cfgRdData[31:8] == 24'h0));

  // R11: other dwords read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDwAddr != 6'h11 && cfgDwAddr != 6'h12) |-> (cfgRdData == 32'h0));

  // R2: without a write, the addressed read value holds
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgSel && cfgWrite) && $stable(cfgDwAddr)) |-> $stable(cfgRdData));

  // R10: at most one line active
  p_one_line_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqLow, ~irqHighN}));

  // R10: no SCI, every line inactive
  p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rstN)
    !sciEvent |-> (irqLow == 3'b000 && irqHighN == 4'b1111));
endmodule

bind pm_decode_router pm_decode_router_chk chk_i (.*);

// File: tb/pm_decode_router_tb_top.sv
module pm_decode_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgSel, cfgWrite;
  logic [5:0]  cfgDwAddr;
  logic [3:0]  cfgByteEn;
  logic [31:0] cfgWrData, cfgRdData;
  logic [15:0] ioAddr;
  logic [8:0]  acpiBase;
  logic        acpiHit, apmHit, gpioHit;
  logic        apicEn, sciEvent;
  logic [2:0]  irqLow;
  logic [3:0]  irqHighN;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  logic [7:0]  mAcpi;
  logic [31:0] mGpio;

  always #2.5 clk = ~clk;

  pm_decode_router dut_i (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, compare 1 ns later, update the model at the rising edge
  task automatic step(string tag, logic sel, logic wr, logic [5:0] dw, logic [3:0] be,
                      logic [31:0] wd, logic [15:0] io, logic sci, logic apic);
    logic [31:0] eRd;
    logic [2:0]  s;
    logic [2:0]  eLow;
    logic [3:0]  eHigh;
    cfgSel = sel; cfgWrite = wr; cfgDwAddr = dw; cfgByteEn = be; cfgWrData = wd;
    ioAddr = io; sciEvent = sci; apicEn = apic;
    #1;
    eRd = (dw == 6'h11) ? {24'h0, mAcpi} : (dw == 6'h12) ? mGpio : 32'h0;
    s = mAcpi[2:0];
    eLow  = (sci && s < 3'd3) ? 3'(1 << s) : 3'b000;
    eHigh = 4'hF ^ ((sci && apic && s >= 3'd4) ? 4'(1 << (s - 3'd4)) : 4'h0);
    chk(tag, "cfgRdData", cfgRdData, eRd);
    chk(tag, "acpiHit", 32'(acpiHit), 32'(mAcpi[7] && io[15:7] == acpiBase));
    chk(tag, "apmHit", 32'(apmHit), 32'(io == 16'h00B2 || io == 16'h00B3));
    chk(tag, "gpioHit", 32'(gpioHit), 32'(io[15:6] == mGpio[15:6]));
    chk(tag, "irqLow", 32'(irqLow), 32'(eLow));
    chk(tag, "irqHighN", 32'(irqHighN), 32'(eHigh));
    @(posedge clk);
    if (rstN && sel && wr) begin
      if (dw == 6'h11 && be[0]) mAcpi = wd[7:0] & 8'h87;
      if (dw == 6'h12) begin
        if (be[0]) mGpio[7:6]  = wd[7:6];
        if (be[1]) mGpio[15:8] = wd[15:8];
      end
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rstN = 1'b0; cfgSel = 0; cfgWrite = 0; cfgDwAddr = 0; cfgByteEn = 0; cfgWrData = 0;
    ioAddr = 0; acpiBase = 9'd8; apicEn = 0; sciEvent = 0;
    mAcpi = 8'h00; mGpio = 32'h1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    step("R1", 0, 0, 6'h11, 0, 0, 16'h0000, 0, 0);
    step("R1", 0, 0, 6'h12, 0, 0, 16'h0000, 0, 0);
    // R4 APM ports with decode off; R3 ACPI window off
    step("R4", 0, 0, 6'h11, 0, 0, 16'h00B2, 0, 0);
    step("R4", 0, 0, 6'h11, 0, 0, 16'h00B3, 0, 0);
    step("R4", 0, 0, 6'h11, 0, 0, 16'h01B2, 0, 0);
    step("R3", 0, 0, 6'h11, 0, 0, 16'h0400, 0, 0);
    // R2 write without lane 0 is ignored, then a real write
    step("R2", 1, 1, 6'h11, 4'b1110, 32'hFFFF_FFFF, 16'h0400, 0, 0);
    step("R2", 1, 1, 6'h11, 4'b0001, 32'hFFFF_FFFF, 16'h0400, 0, 0);
    step("R2", 0, 0, 6'h11, 0, 0, 16'h0400, 0, 0);
    step("R3", 0, 0, 6'h11, 0, 0, 16'h047F, 0, 0);
    step("R3", 0, 0, 6'h11, 0, 0, 16'h0480, 0, 0);
    step("R3", 0, 0, 6'h11, 0, 0, 16'h03FF, 0, 0);
    step("R4", 0, 0, 6'h11, 0, 0, 16'h00B3, 0, 0);

    // R7 R8 R9 route codes under both extended-mode settings
    for (int c = 0; c < 8; c++) begin
      step("R2", 1, 1, 6'h11, 4'b0001, 32'h80 | 32'(c), 16'h0400, 0, 0);
      for (int m = 0; m < 4; m++)
        step(c < 3 ? "R7" : (c == 3 ? "R9" : (m[1] ? "R8" : "R9")),
             0, 0, 6'h11, 0, 0, 16'h0400, m[0], m[1]);
    end
    step("R3", 1, 1, 6'h11, 4'b0001, 32'h0000_0004, 16'h0400, 1, 1);
    step("R3", 0, 0, 6'h11, 0, 0, 16'h0400, 1, 1);

    // R5 GPIO byte lanes and fixed bits; R6 window
    step("R5", 1, 1, 6'h12, 4'b0001, 32'hFFFF_FFFF, 16'h0000, 0, 0);
    step("R5", 1, 1, 6'h12, 4'b0010, 32'hFFFF_FFFF, 16'h0000, 0, 0);
    step("R5", 1, 1, 6'h12, 4'b1100, 32'h0000_0000, 16'hFFC0, 0, 0);
    step("R6", 0, 0, 6'h12, 0, 0, 16'hFFFF, 0, 0);
    step("R6", 0, 0, 6'h12, 0, 0, 16'hFFBF, 0, 0);
    step("R5", 1, 1, 6'h12, 4'b0011, 32'h0000_1240, 16'h1240, 0, 0);
    step("R6", 0, 0, 6'h12, 0, 0, 16'h1240, 0, 0);
    step("R6", 0, 0, 6'h12, 0, 0, 16'h127F, 0, 0);
    step("R6", 0, 0, 6'h12, 0, 0, 16'h1280, 0, 0);

    // R11 unmapped dwords
    step("R11", 1, 1, 6'h10, 4'b1111, 32'hFFFF_FFFF, 16'h0000, 0, 0);
    step("R11", 1, 1, 6'h13, 4'b1111, 32'h0000_0000, 16'h0000, 0, 0);
    step("R11", 0, 0, 6'h10, 0, 0, 16'h0000, 0, 0);
    step("R11", 0, 0, 6'h11, 0, 0, 16'h0000, 0, 0);
    step("R11", 0, 0, 6'h12, 0, 0, 16'h0000, 0, 0);

    // R10 mixed sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = (lfsr[3:0] == 4'h5);
      step("R10", w, w, lfsr[7] ? 6'h11 : 6'h12, 4'b0011, {16'h0, lfsr[15:8], lfsr[7:0]},
           {lfsr[9:0], lfsr[15:10]} & (lfsr[1] ? 16'h04FF : 16'hFFFF), lfsr[2], lfsr[5]);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule